// File: doc/BRIEF.md
# Nibble-Indexed Byte Shuffle Unit

This unit rearranges bytes. Two 64-bit operands, A and B, are treated as one 16-byte pool. Each of the eight result bytes picks any byte from that pool, using its own 4-bit selector. All eight selectors come from a mask register. A write port loads the mask, and one setup then serves any number of later shuffles.

A shuffle is issued by raising `in_valid` with both operands present. The chosen bytes are registered, and `out_valid` marks the cycle in which they appear.

The output stage is a two-state machine:

- `ST_EMPTY`: no fresh result this cycle.
- `ST_LOADED`: a result was captured at the last edge.
- Transition *capture* (any state to `ST_LOADED`): taken when `in_valid` is high.
- Transition *drain* (any state to `ST_EMPTY`): taken when `in_valid` is low.
- Reset forces `ST_EMPTY`.

Top module: `nib_shuffle_top`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears `out_valid` to 0, `out_data` to 0 and the mask register to 0.
- R2: When `cfg_we` is high at a clock edge, the mask register takes `cfg_word[63:32]`. Bits 31:0 of `cfg_word` have no effect on any later result.
- R3: Result byte position i (0 to 7) sits at `out_data[63-8i:56-8i]`, so position 0 is the most significant byte. Its selector is mask bits `31-4i:28-4i`. A selector value k from 0 to 7 picks `src_a[63-8k:56-8k]`, so k = 0 is the most significant byte of A.
- R4: A selector value k from 8 to 15 picks `src_b[63-8(k-8):56-8(k-8)]`, so k = 8 is the most significant byte of B.
- R5: The eight positions select independently. Repeated selectors and any ordering of selectors are honoured.
- R6: When `cfg_we` and `in_valid` are both high in the same cycle, that shuffle uses the mask held before the write. The new mask applies from the next shuffle on.
- R7: `out_valid` is high in the cycle after an edge with `in_valid` high, and low in the cycle after an edge with `in_valid` low.
- R8: `out_data` keeps its value across an edge at which `in_valid` is low, whatever the operands are.
- R9: With the reset mask (all zero), every result byte equals the most significant byte of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Mask write strobe |
| cfg_word | input | 64 | Status word; the upper half becomes the mask |
| in_valid | input | 1 | Shuffle request strobe |
| src_a | input | 64 | First operand, pool bytes 0 to 7 |
| src_b | input | 64 | Second operand, pool bytes 8 to 15 |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 64 | Registered shuffle result |

## Verification
The bench builds the unit with its default parameters: eight result lanes of eight bits and 4-bit selectors. At this size every pairing of one result lane with one selector value fits in 128 cases. The sweep sets each lane to each of the 16 selector values while the other lanes keep the identity ordering, so every path in every lane's selector is exercised. Beyond the sweep, the bench applies the identity mask, the mask that selects all of B, repeated-selector masks, a mask write in the same cycle as a shuffle, and random masks. Every expected result is computed arithmetically from the selector nibbles.

// File: rtl/nsh_pkg.sv
package nsh_pkg;

    // Default geometry: eight result lanes of one byte each
    localparam int unsigned DEF_LANES  = 8;
    localparam int unsigned DEF_BYTE_W = 8;

    // Output stage occupancy
    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } out_state_t;

endpackage

// File: rtl/nsh_mask_reg.sv
module nsh_mask_reg #(
    parameter int unsigned MASK_W = 32,
    parameter int unsigned STAT_W = 2 * MASK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [STAT_W-1:0] wdata,
    output logic [MASK_W-1:0] mask_q
);

    // Only the upper part of the status word carries selectors
    logic [MASK_W-1:0] upper;
    assign upper = wdata[STAT_W-1 -: MASK_W];

    logic unused_low_half;
    assign unused_low_half = ^wdata[STAT_W-MASK_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (we) begin
            mask_q <= upper;
        end
    end

endmodule

// File: rtl/nsh_lane_sel.sv
module nsh_lane_sel #(
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned SRC_BYTES = 16,
    parameter int unsigned IDX_W     = $clog2(SRC_BYTES)
) (
    input  logic [SRC_BYTES*BYTE_W-1:0] pool,
    input  logic [IDX_W-1:0]            idx,
    output logic [BYTE_W-1:0]           sel
);

    // Pool byte k lives at the k-th byte counted from the top
    always_comb begin
        sel = '0;
        for (int k = 0; k < SRC_BYTES; k++) begin
            if (idx == IDX_W'(k)) begin
                sel = pool[(SRC_BYTES-1-k)*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/nsh_xbar.sv
module nsh_xbar #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned SRC_BYTES = 2 * LANES,
    localparam int unsigned IDX_W     = $clog2(SRC_BYTES),
    localparam int unsigned MASK_W    = LANES * IDX_W,
    localparam int unsigned DATA_W    = LANES * BYTE_W
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [MASK_W-1:0] mask,
    output logic [DATA_W-1:0] shuffled
);

    logic [2*DATA_W-1:0] pool;
    assign pool = {op_a, op_b};

    // One independent selector per result lane, lane 0 at the top
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        nsh_lane_sel #(
            .BYTE_W   (BYTE_W),
            .SRC_BYTES(SRC_BYTES),
            .IDX_W    (IDX_W)
        ) u_sel (
            .pool(pool),
            .idx (mask[(LANES-1-i)*IDX_W +: IDX_W]),
            .sel (shuffled[(LANES-1-i)*BYTE_W +: BYTE_W])
        );
    end

endmodule

// File: rtl/nsh_out_stage.sv
module nsh_out_stage
    import nsh_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] d_in,
    output logic              q_valid,
    output logic [DATA_W-1:0] q_data
);

    out_state_t state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = capture ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = capture ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Data register: loads only on a request, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data <= '0;
        end else if (capture) begin
            q_data <= d_in;
        end
    end

    assign q_valid = (state_q == ST_LOADED);

endmodule

// File: rtl/nib_shuffle_top.sv
module nib_shuffle_top
    import nsh_pkg::*;
#(
    parameter int unsigned LANES  = DEF_LANES,
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    localparam int unsigned IDX_W  = $clog2(2 * LANES),
    localparam int unsigned MASK_W = LANES * IDX_W,
    localparam int unsigned STAT_W = 2 * MASK_W,
    localparam int unsigned DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [STAT_W-1:0] cfg_word,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [MASK_W-1:0] mask_q;
    logic [DATA_W-1:0] shuffled;

    nsh_mask_reg #(
        .MASK_W(MASK_W),
        .STAT_W(STAT_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_word),
        .mask_q(mask_q)
    );

    nsh_xbar #(
        .LANES (LANES),
        .BYTE_W(BYTE_W)
    ) u_xbar (
        .op_a    (src_a),
        .op_b    (src_b),
        .mask    (mask_q),
        .shuffled(shuffled)
    );

    nsh_out_stage #(
        .DATA_W(DATA_W)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(in_valid),
        .d_in   (shuffled),
        .q_valid(out_valid),
        .q_data (out_data)
    );

endmodule

// File: rtl/nsh_chk.sv
module nsh_chk #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned IDX_W  = $clog2(2 * LANES),
    localparam int unsigned MASK_W = LANES * IDX_W,
    localparam int unsigned DATA_W = LANES * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [MASK_W-1:0] mask
);

    logic [IDX_W-1:0] lane0_idx;
    assign lane0_idx = mask[MASK_W-1 -: IDX_W];

    // R7: valid follows the request by one cycle
    assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: no request, no change in the held result
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R3: selector 0 in lane 0 returns the top byte of A
    assert_sel_a_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane0_idx == '0) |=>
            out_data[DATA_W-1 -: BYTE_W] == $past(src_a[DATA_W-1 -: BYTE_W]));

    // R4: selector LANES in lane 0 returns the top byte of B
    assert_sel_b_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane0_idx == IDX_W'(LANES)) |=>
            out_data[DATA_W-1 -: BYTE_W] == $past(src_b[DATA_W-1 -: BYTE_W]));

    // R9: an all-zero mask replicates the top byte of A
    assert_zero_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask == '0) |=>
            out_data == {LANES{$past(src_a[DATA_W-1 -: BYTE_W])}});

endmodule

bind nib_shuffle_top nsh_chk #(
    .LANES (LANES),
    .BYTE_W(BYTE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .src_a    (src_a),
    .src_b    (src_b),
    .out_valid(out_valid),
    .out_data (out_data),
    .mask     (mask_q)
);

// File: tb/sim_nib_shuffle_top.sv
module sim_nib_shuffle_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [63:0] cfg_word = '0;
    logic        in_valid = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nib_shuffle_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_word (cfg_word),
        .in_valid (in_valid),
        .src_a    (src_a),
        .src_b    (src_b),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    // Expected result computed from the selector nibbles
    function automatic logic [63:0] model(input logic [31:0] m,
                                          input logic [63:0] a,
                                          input logic [63:0] b);
        logic [127:0] pool;
        logic [63:0]  r;
        pool = {a, b};
        r = '0;
        for (int i = 0; i < 8; i++) begin
            int k;
            k = int'(m[31-4*i -: 4]);
            r[63-8*i -: 8] = pool[127-8*k -: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] ident_with(input int lane, input int idx);
        logic [31:0] m;
        m = 32'h0123_4567;
        m[31-4*lane -: 4] = idx[3:0];
        return m;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Both tasks start and end just after a falling edge
    task automatic write_cfg(input logic [63:0] w);
        cfg_we = 1'b1;
        cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_word = ~w;
    endtask

    task automatic shuffle_chk(input string tag, input logic [63:0] a,
                               input logic [63:0] b, input logic [63:0] exp);
        in_valid = 1'b1;
        src_a = a;
        src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        chk(tag, out_data, exp);
    endtask

    localparam logic [63:0] OPA = 64'h0011_2233_4455_6677;
    localparam logic [63:0] OPB = 64'h8899_AABB_CCDD_EEFF;

    initial begin
        logic [31:0] held;
        logic [63:0] keep;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1 out_data", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset mask copies the top byte of A everywhere
        shuffle_chk("R9 zero mask", OPA, OPB, {8{OPA[63:56]}});

        // R2, R3: identity mask, lower status half set to ones
        write_cfg({32'h0123_4567, 32'hFFFF_FFFF});
        shuffle_chk("R3 identity", OPA, OPB, OPA);
        shuffle_chk("R2 low half ignored", OPB, OPA, OPB);

        // R4: all of B
        write_cfg({32'h89AB_CDEF, 32'h0123_4567});
        shuffle_chk("R4 all of B", OPA, OPB, OPB);

        // R3, R4: each lane against each selector value
        for (int lane = 0; lane < 8; lane++) begin
            for (int idx = 0; idx < 16; idx++) begin
                held = ident_with(lane, idx);
                write_cfg({held, 32'h0});
                shuffle_chk(idx < 8 ? "R3 sweep" : "R4 sweep", OPA, OPB,
                            model(held, OPA, OPB));
            end
        end

        // R5: repeated and reversed selectors
        write_cfg({32'h00FF_00FF, 32'h0});
        shuffle_chk("R5 repeated", OPA, OPB, model(32'h00FF_00FF, OPA, OPB));
        write_cfg({32'hFEDC_BA98, 32'h0});
        shuffle_chk("R5 reversed", OPA, OPB, model(32'hFEDC_BA98, OPA, OPB));

        // R6: a write in the same cycle as a shuffle does not affect it
        write_cfg({32'h7654_3210, 32'h0});
        cfg_we = 1'b1;
        cfg_word = {32'h89AB_CDEF, 32'h0};
        shuffle_chk("R6 old mask", OPA, OPB, model(32'h7654_3210, OPA, OPB));
        cfg_we = 1'b0;
        shuffle_chk("R6 new mask", OPA, OPB, OPB);

        // R7, R8: idle cycle with changing operands
        keep = out_data;
        src_a = ~OPA;
        src_b = ~OPB;
        @(negedge clk);
        chk("R7 valid low", {63'd0, out_valid}, 64'd0);
        chk("R8 hold", out_data, keep);
        src_a = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        chk("R8 hold again", out_data, keep);

        // R5: random masks and operands
        for (int n = 0; n < 200; n++) begin
            logic [63:0] ra;
            logic [63:0] rb;
            held = $urandom;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            write_cfg({held, $urandom});
            shuffle_chk("R5 random", ra, rb, model(held, ra, rb));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule